// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a 3½-digit integrating converter. A divider turns the master clock into count ticks. A sequencer steps through three analog phases: zeroing, fixed-length integration of the input, and integration of the reference back to zero. The sequencer drives one-hot enables for the external analog switches. It samples a comparator that reports when the integrator has returned to zero.

A four-digit BCD counter measures the length of the reference phase. At the end of that phase the count becomes the reading. The reading, the sign of the input and an overrange flag are latched together and offered on a valid/ready output. The converter never stalls: if the consumer holds ready low, `rd_valid` stays high and the next result overwrites the held one. The zeroing phase absorbs whatever time the reference phase did not use, so every conversion has the same length.

Top module: `dual_slope_seq`

## Requirements
- R1: A count tick occurs once every 4 master clocks. All phase lengths and readings are measured in ticks.
- R2: Exactly one of `ph_az`, `ph_int`, `ph_deint` is high at any time. The phases always run zeroing, then integrate, then reference, then back to zeroing.
- R3: The integrate phase lasts exactly 1000 ticks (4000 clocks).
- R4: `cmp_zero` is only sampled on ticks during the reference phase, and is ignored in all other phases. If it is first seen high on the (N+1)-th tick of that phase, the phase ends on that tick, lasts 4·(N+1) clocks, and the reading is N.
- R5: `sign_neg` is sampled on the last tick of integration. It drives `ref_neg` steady for the whole reference phase and is latched as `rd_neg`. Changes to `sign_neg` during the reference phase have no effect.
- R6: If 2000 ticks pass in the reference phase without `cmp_zero`, the phase ends. The reading is 1999 and `rd_over` is 1. A zero crossing seen on the 2000th tick instead gives 1999 with `rd_over` 0.
- R7: From one rise of `ph_int` to the next there are always 16000 clocks, whatever the reading.
- R8: `rd_bcd` holds four BCD digits: thousands in [15:12], hundreds in [11:8], tens in [7:4], units in [3:0]. Each digit is 0 to 9, and the thousands digit is 0 or 1.
- R9: `rd_valid` rises on the clock that latches a result. It stays high, with the data held, until a clock with `rd_ready` high. A new result replaces an unacknowledged one.
- R10: A synchronous reset puts the block in the zeroing phase with all counters at zero and `rd_valid`, `rd_bcd`, `rd_neg`, `rd_over` and `ref_neg` at 0. The first integrate phase starts 16000 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_zero | input | 1 | Comparator: integrator has returned to zero |
| sign_neg | input | 1 | Comparator polarity: integrated input is negative |
| rd_ready | input | 1 | Consumer accepts the result |
| ph_az | output | 1 | Zeroing phase switch enable |
| ph_int | output | 1 | Input integrate switch enable |
| ph_deint | output | 1 | Reference integrate switch enable |
| ref_neg | output | 1 | Reference polarity to apply during the reference phase |
| rd_valid | output | 1 | Result available |
| rd_bcd | output | 16 | Latched reading, four BCD digits |
| rd_neg | output | 1 | Latched sign of the reading |
| rd_over | output | 1 | Latched overrange flag |

## Verification
The assertions assume that reset is applied at start-up. They assume nothing about `cmp_zero` or `sign_neg`: both may change on any clock and are simply ignored outside their sampling ticks. The stimulus drives these two inputs only at falling clock edges. It raises `cmp_zero` a computed number of clocks after the reference phase begins, so the stopping tick is known exactly. It also toggles both inputs outside their sampling windows to show that they are ignored.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    PH_ZERO  = 2'd0,
    PH_INTEG = 2'd1,
    PH_REF   = 2'd2
  } phase_e;
endpackage

// File: rtl/dsc_prescale.sv
module dsc_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] cnt;

  assign tick = (cnt == DW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || tick) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R1: ticks are never adjacent when the divide ratio exceeds one
  generate
    if (DIV > 1) begin : g_spacing
      p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dsc_bcd_counter.sv
module dsc_bcd_counter #(
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  inc,
  output logic [4*DIGITS-1:0]   value
);
  logic [DIGITS:0] carry;

  assign carry[0] = inc;

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : g_dig
      logic [3:0] dig;
      assign value[4*d +: 4] = dig;
      assign carry[d+1]      = carry[d] && (dig == 4'd9);

      always_ff @(posedge clk) begin
        if (rst || clr)     dig <= 4'd0;
        else if (carry[d])  dig <= (dig == 4'd9) ? 4'd0 : dig + 4'd1;
      end

      // R8: every decade stays a legal BCD digit
      p_digit_range_r8: assert property (@(posedge clk) disable iff (rst)
        dig <= 4'd9);
    end
  endgenerate
endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
  import dsc_pkg::*;
#(
  parameter int DIGITS    = 4,
  parameter int INT_CNT   = 1000,
  parameter int REF_MAX   = 2000,
  parameter int CYCLE_CNT = 4000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                cmp_zero,
  input  logic                sign_neg,
  input  logic                rd_ready,
  input  logic [4*DIGITS-1:0] count,
  output logic                cnt_clr,
  output logic                cnt_inc,
  output phase_e              phase,
  output logic                ref_neg,
  output logic                rd_valid,
  output logic [4*DIGITS-1:0] rd_bcd,
  output logic                rd_neg,
  output logic                rd_over
);
  localparam int CW = $clog2(CYCLE_CNT);

  function automatic logic [4*DIGITS-1:0] to_bcd(input int v);
    logic [4*DIGITS-1:0] r;
    int t;
    r = '0;
    t = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  localparam logic [4*DIGITS-1:0] FULL_BCD = to_bcd(REF_MAX - 1);

  logic [CW-1:0] cyc;
  logic          hit_zero;
  logic          hit_full;
  logic          done;

  assign hit_zero = tick && (phase == PH_REF) && cmp_zero;
  assign hit_full = tick && (phase == PH_REF) && !cmp_zero && (count == FULL_BCD);
  assign done     = hit_zero || hit_full;
  assign cnt_inc  = tick && (phase == PH_REF) && !done;
  assign cnt_clr  = tick && (phase == PH_INTEG) && (cyc == CW'(INT_CNT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_ZERO;
      cyc     <= '0;
      ref_neg <= 1'b0;
    end else if (tick) begin
      unique case (phase)
        PH_ZERO: begin
          if (cyc == CW'(CYCLE_CNT - 1)) begin
            cyc   <= '0;
            phase <= PH_INTEG;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        PH_INTEG: begin
          cyc <= cyc + 1'b1;
          if (cyc == CW'(INT_CNT - 1)) begin
            phase   <= PH_REF;
            ref_neg <= sign_neg;
          end
        end
        PH_REF: begin
          cyc <= cyc + 1'b1;
          if (done) phase <= PH_ZERO;
        end
        default: phase <= PH_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_bcd   <= '0;
      rd_neg   <= 1'b0;
      rd_over  <= 1'b0;
    end else if (done) begin
      rd_valid <= 1'b1;
      rd_bcd   <= count;
      rd_neg   <= ref_neg;
      rd_over  <= hit_full;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  // R2: the reference phase is only ever entered from integration
  p_order_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_REF) && $past(phase) != PH_REF |-> $past(phase) == PH_INTEG);
  // R5: reference polarity is steady across the reference phase
  p_pol_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_REF) && $past(phase) == PH_REF |-> $stable(ref_neg));
  // R9: an unacknowledged result is held
  p_valid_hold_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready && !done |=> rd_valid && $stable(rd_bcd));
  // R8: the thousands digit of any latched reading is 0 or 1
  p_msd_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_bcd[4*DIGITS-1 -: 4] <= 4'd1);
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int DIGITS    = 4,
  parameter int INT_CNT   = 1000,
  parameter int REF_MAX   = 2000,
  parameter int CYCLE_CNT = 4000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmp_zero,
  input  logic                sign_neg,
  input  logic                rd_ready,
  output logic                ph_az,
  output logic                ph_int,
  output logic                ph_deint,
  output logic                ref_neg,
  output logic                rd_valid,
  output logic [4*DIGITS-1:0] rd_bcd,
  output logic                rd_neg,
  output logic                rd_over
);
  logic                tick;
  logic                cnt_clr;
  logic                cnt_inc;
  logic [4*DIGITS-1:0] count;
  phase_e              phase;

  dsc_prescale #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  dsc_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .value (count)
  );

  dsc_sequencer #(
    .DIGITS    (DIGITS),
    .INT_CNT   (INT_CNT),
    .REF_MAX   (REF_MAX),
    .CYCLE_CNT (CYCLE_CNT)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cmp_zero (cmp_zero),
    .sign_neg (sign_neg),
    .rd_ready (rd_ready),
    .count    (count),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .phase    (phase),
    .ref_neg  (ref_neg),
    .rd_valid (rd_valid),
    .rd_bcd   (rd_bcd),
    .rd_neg   (rd_neg),
    .rd_over  (rd_over)
  );

  assign ph_az    = (phase == PH_ZERO);
  assign ph_int   = (phase == PH_INTEG);
  assign ph_deint = (phase == PH_REF);

  // R2: switch enables are one-hot
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({ph_az, ph_int, ph_deint}) == 1);
endmodule

// File: tb/dual_slope_seq_tb.sv
module dual_slope_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_zero = 1'b0;
  logic        sign_neg = 1'b0;
  logic        rd_ready = 1'b0;
  logic        ph_az, ph_int, ph_deint, ref_neg;
  logic        rd_valid, rd_neg, rd_over;
  logic [15:0] rd_bcd;

  int unsigned ncyc = 0;
  int          n_chk = 0;
  int          n_err = 0;
  int unsigned last_int = 0;
  bit          have_int = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  dual_slope_seq u_dut (
    .clk(clk), .rst(rst), .cmp_zero(cmp_zero), .sign_neg(sign_neg),
    .rd_ready(rd_ready), .ph_az(ph_az), .ph_int(ph_int), .ph_deint(ph_deint),
    .ref_neg(ref_neg), .rd_valid(rd_valid), .rd_bcd(rd_bcd),
    .rd_neg(rd_neg), .rd_over(rd_over)
  );

  function automatic logic [15:0] bcd_of(input int v);
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, ncyc);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 az after reset", ph_az, 1);
    chk("R10 valid cleared", rd_valid, 0);
    chk("R10 reading cleared", rd_bcd, 0);
    chk("R10 flags cleared", {rd_neg, rd_over, ref_neg}, 0);
    rst = 1'b0;
    begin
      int unsigned t0 = ncyc;
      while (!ph_int) @(negedge clk);
      chk("R10 first integrate delay", ncyc - t0, 16000);
    end
  endtask

  // n < 0 means no zero crossing (overrange)
  task automatic t_conv(input string name, input int n, input bit sgn,
                        input bit noise, input bit ack, input bit prev_unacked);
    int unsigned ta, tb, te;
    int expn;
    while (!ph_int) @(negedge clk);
    ta = ncyc;
    if (prev_unacked) chk({"R9 held across cycle ", name}, rd_valid, 1);
    if (have_int) chk({"R7 cycle length ", name}, ta - last_int, 16000);
    last_int = ta;
    have_int = 1'b1;
    sign_neg = sgn;
    if (noise) cmp_zero = 1'b1;   // R4: ignored during integration
    while (!ph_deint) @(negedge clk);
    tb = ncyc;
    cmp_zero = 1'b0;
    chk({"R3 integrate length ", name}, tb - ta, 4000);
    chk({"R5 ref polarity ", name}, ref_neg, sgn);
    sign_neg = ~sgn;              // R5: must not disturb the held polarity
    if (n >= 0) begin
      while (ncyc != tb + 4 * n) @(negedge clk);
      chk({"R5 ref polarity held ", name}, ref_neg, sgn);
      cmp_zero = 1'b1;
    end
    while (ph_deint) @(negedge clk);
    te = ncyc;
    expn = (n >= 0) ? n : 1999;
    chk({"R4 ref phase length ", name}, te - tb, (n >= 0) ? 4 * (n + 1) : 8000);
    chk({"R2 back to zeroing ", name}, ph_az, 1);
    chk({"R9 valid raised ", name}, rd_valid, 1);
    chk({"R8 reading ", name}, rd_bcd, bcd_of(expn));
    chk({"R5 latched sign ", name}, rd_neg, sgn);
    chk({"R6 overrange flag ", name}, rd_over, (n < 0));
    if (noise) cmp_zero = 1'b1;   // R4: ignored during zeroing
    else cmp_zero = 1'b0;
    repeat (3) @(negedge clk);
    chk({"R9 valid held ", name}, rd_valid, 1);
    chk({"R4 reading kept ", name}, rd_bcd, bcd_of(expn));
    if (ack) begin
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      chk({"R9 valid cleared ", name}, rd_valid, 0);
    end
    cmp_zero = 1'b0;
  endtask

  initial begin
    t_reset();
    t_conv("mid",  537, 1'b1, 1'b1, 1'b1, 1'b0);
    t_conv("zero", 0,   1'b0, 1'b0, 1'b1, 1'b0);
    t_conv("over", -1,  1'b1, 1'b0, 1'b1, 1'b0);
    t_conv("edge", 1999, 1'b0, 1'b0, 1'b0, 1'b0);
    t_conv("ovwr", 1000, 1'b1, 1'b0, 1'b1, 1'b1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=done", ncyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule